// File: doc/BRIEF.md
# Idle-Deleting Elastic Rate Buffer

This block carries a stream of 32-bit columns (four byte lanes, each lane with its own control flag) from a write clock to a read clock. The two clocks are nominally equal but may drift apart by up to 200 ppm. The write side takes one column every write cycle, and the read side emits one column every read cycle. To keep the fill level bounded, the buffer drops or adds whole all-idle columns. It does this only in the idle gaps between packets and never changes a column that carries packet data.

The write side keeps a deletion request once its fill level reaches a high mark. The request stays pending, across as many packets as needed, until it meets an all-idle column. At that point the gap bytes already kept since the terminate character must reach eight. The deletion then clears the request. The read side adds an all-idle column when its fill level is below a low mark and the last column it emitted left the stream between packets. Pointers cross between the domains in gray code. Overflow and underflow raise sticky error flags.

Top module: `idle_elastic_buf`

## Requirements
- R1: Every column written that is not all-idle appears at the read port once, unchanged and in write order.
- R2: Idle is added or removed only as whole all-idle columns (control flags 4'hF, every byte 8'h07). Partial idle columns pass through unchanged.
- R3: A column written while the buffer holds 2**AW columns is dropped, and `wr_ovf` is set and stays set until write reset.
- R4: If the read side must emit a column inside a packet while the buffer is empty, it emits an all-idle column, and `rd_unf` is set and stays set until read reset.
- R5: A write-side fill level of at least HIGH_MARK raises a deletion request. The request is held until exactly one all-idle column is removed, and the buffer does not overflow at a 5 percent clock offset with regular gaps.
- R6: A column is deleted only if at least 8 gap bytes, counting the terminate byte, have already been kept in the current gap. So every gap at the output is at least the smaller of its input length and 8 bytes.
- R7: Minimum gaps (terminate in lane 3 followed by one idle column, 5 bytes) reach the output with no column removed.
- R8: An all-idle column is added only when the read-side fill level is below LOW_MARK and the previous output column left the stream between packets. No all-idle column ever appears inside a packet unless an underflow occurred.
- R9: Idle is 8'h07, start is 8'hFB and terminate is 8'hFD, each with its lane control flag set. A start is valid only in lane 0 (bits 7:0), and a start never appears in lanes 1 to 3 at the output.
- R10: After reset the read port shows an all-idle column and both error flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| wr_rst_n | input | 1 | Active-low write-domain reset |
| wr_data | input | 32 | Write column, lane 0 in bits 7:0 |
| wr_ctrl | input | 4 | Control flag per write lane |
| wr_ovf | output | 1 | Sticky overflow flag |
| rd_clk | input | 1 | Read clock |
| rd_rst_n | input | 1 | Active-low read-domain reset |
| rd_data | output | 32 | Read column, registered |
| rd_ctrl | output | 4 | Control flag per read lane |
| rd_unf | output | 1 | Sticky underflow flag |

## Verification
A column enters memory on the write edge that samples it. The read side sees it only after the two-flop gray synchronizer, and it reaches the registered read port one read edge after it is selected. That makes the delay variable, from about three read cycles upward. For this reason the reference model compares the output stream by order, not by cycle. On each falling read edge it matches every column that is not all-idle against the head of a queue of written columns. It measures each output gap against the input gap recorded for the same packet. Flag checks wait hundreds of columns after the stimulus that should trip them, well beyond the synchronizer delay.

// File: rtl/idle_elastic_buf.sv
module idle_elastic_buf #(
  parameter int AW        = 4,
  parameter int HIGH_MARK = 12,
  parameter int LOW_MARK  = 4
) (
  input  logic        wr_clk,
  input  logic        wr_rst_n,
  input  logic [31:0] wr_data,
  input  logic [3:0]  wr_ctrl,
  output logic        wr_ovf,
  input  logic        rd_clk,
  input  logic        rd_rst_n,
  output logic [31:0] rd_data,
  output logic [3:0]  rd_ctrl,
  output logic        rd_unf
);
  localparam int PW = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam logic [31:0] IDLE4 = {4{8'h07}};
  localparam logic [7:0] K_START = 8'hFB;
  localparam logic [7:0] K_TERM = 8'hFD;

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [35:0] mem [DEPTH];

  // write domain
  logic [PW-1:0] wbin, wgray, rg_s1, rg_s2, rgray;
  logic [7:0] gap_cnt;
  logic in_gap, del_pend, term_hit;
  logic [2:0] term_gap;

  wire [PW-1:0] wr_level = wbin - from_gray(rg_s2);
  wire col_idle  = (wr_ctrl == 4'hF) && (wr_data == IDLE4);
  wire col_start = wr_ctrl[0] && (wr_data[7:0] == K_START);
  wire full      = (wr_level == PW'(DEPTH));
  wire del_ok    = del_pend && col_idle && in_gap && (gap_cnt >= 8'd8);
  wire do_wr     = !del_ok && !full;
  wire [PW-1:0] wbin_nx = wbin + PW'(do_wr);

  always_comb begin
    term_hit = 1'b0;
    term_gap = 3'd0;
    for (int i = 3; i >= 0; i--)
      if (wr_ctrl[i] && wr_data[8*i +: 8] == K_TERM) begin
        term_hit = 1'b1;
        term_gap = 3'(4 - i);
      end
  end

  always_ff @(posedge wr_clk)
    if (do_wr) mem[wbin[AW-1:0]] <= {wr_ctrl, wr_data};

  always_ff @(posedge wr_clk or negedge wr_rst_n)
    if (!wr_rst_n) begin
      wbin <= '0; wgray <= '0; rg_s1 <= '0; rg_s2 <= '0;
      wr_ovf <= 1'b0; del_pend <= 1'b0; in_gap <= 1'b1; gap_cnt <= 8'd8;
    end else begin
      wbin  <= wbin_nx;
      wgray <= to_gray(wbin_nx);
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
      if (!del_ok && full) wr_ovf <= 1'b1;
      if (del_ok) del_pend <= 1'b0;
      else if (wr_level >= PW'(HIGH_MARK)) del_pend <= 1'b1;
      if (col_start) begin
        in_gap <= 1'b0; gap_cnt <= 8'd0;
      end else if (term_hit) begin
        in_gap <= 1'b1; gap_cnt <= 8'(term_gap);
      end else if (in_gap && !del_ok && gap_cnt < 8'd252)
        gap_cnt <= gap_cnt + 8'd4;
    end

  p_ovf_sticky_r3: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_ovf |=> wr_ovf);
  p_level_bound_r3: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_level <= PW'(DEPTH));
  p_pend_at_high_r5: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    $rose(del_pend) |-> $past(wr_level) >= PW'(HIGH_MARK));

  // read domain
  logic [PW-1:0] rbin, wg_s1, wg_s2;
  logic out_in_pkt;

  wire [PW-1:0] rd_level = from_gray(wg_s2) - rbin;
  wire empty   = (rd_level == '0);
  wire ins_now = !out_in_pkt && (rd_level < PW'(LOW_MARK));
  wire do_rd   = !ins_now && !empty;
  wire [35:0] nxt = do_rd ? mem[rbin[AW-1:0]] : {4'hF, IDLE4};
  wire [PW-1:0] rbin_nx = rbin + PW'(do_rd);

  logic nxt_term;
  always_comb begin
    nxt_term = 1'b0;
    for (int i = 0; i < 4; i++)
      if (nxt[32+i] && nxt[8*i +: 8] == K_TERM) nxt_term = 1'b1;
  end
  wire nxt_start = nxt[32] && (nxt[7:0] == K_START);

  always_ff @(posedge rd_clk or negedge rd_rst_n)
    if (!rd_rst_n) begin
      rbin <= '0; rgray <= '0; wg_s1 <= '0; wg_s2 <= '0;
      rd_ctrl <= 4'hF; rd_data <= IDLE4; rd_unf <= 1'b0; out_in_pkt <= 1'b0;
    end else begin
      rbin  <= rbin_nx;
      rgray <= to_gray(rbin_nx);
      wg_s1 <= wgray;
      wg_s2 <= wg_s1;
      {rd_ctrl, rd_data} <= nxt;
      if (out_in_pkt && empty) rd_unf <= 1'b1;
      if (nxt_start) out_in_pkt <= 1'b1;
      else if (nxt_term) out_in_pkt <= 1'b0;
    end

  wire out_idle = (rd_ctrl == 4'hF) && (rd_data == IDLE4);
  wire bad_start = (rd_ctrl[1] && rd_data[15:8] == K_START) ||
                   (rd_ctrl[2] && rd_data[23:16] == K_START) ||
                   (rd_ctrl[3] && rd_data[31:24] == K_START);

  p_unf_sticky_r4: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_unf |=> rd_unf);
  p_no_idle_in_pkt_r8: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (out_in_pkt && out_idle) |-> rd_unf);
  p_start_lane0_r9: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !bad_start);
endmodule

// File: tb/idle_elastic_buf_test.sv
`timescale 1ns/1ps
module idle_elastic_buf_test;
  localparam logic [31:0] IDLE4 = {4{8'h07}};
  localparam logic [35:0] IDLECOL = {4'hF, IDLE4};

  real wh = 4.0, rh = 4.0;
  logic wclk = 0, rclk = 0;
  logic wr_rst_n = 0, rd_rst_n = 0;
  logic [31:0] wr_data = IDLE4;
  logic [3:0] wr_ctrl = 4'hF;
  logic wr_ovf, rd_unf;
  logic [31:0] rd_data;
  logic [3:0] rd_ctrl;

  always #(wh) wclk = ~wclk;
  always #(rh) rclk = ~rclk;

  idle_elastic_buf uut (.wr_clk(wclk), .wr_rst_n(wr_rst_n), .wr_data(wr_data),
    .wr_ctrl(wr_ctrl), .wr_ovf(wr_ovf), .rd_clk(rclk), .rd_rst_n(rd_rst_n),
    .rd_data(rd_data), .rd_ctrl(rd_ctrl), .rd_unf(rd_unf));

  int checks = 0, fails = 0;
  logic [35:0] exp_q[$];
  int gap_q[$];
  int prev_gap = 1000, o_gap = 1000;
  bit o_pkt = 0, chk_en = 0;
  logic [7:0] dv = 8'h10;

  task automatic chk(input bit ok, input string req, input string act, input string exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  task automatic put(input logic [3:0] c, input logic [31:0] d);
    @(posedge wclk); #1;
    wr_ctrl = c; wr_data = d;
    if ({c, d} != IDLECOL) exp_q.push_back({c, d});
  endtask

  task automatic idles(input int n);
    for (int i = 0; i < n; i++) put(4'hF, IDLE4);
  endtask

  function automatic logic [7:0] nb();
    dv = dv + 8'd1;
    return dv;
  endfunction

  task automatic send_pkt(input int ncol, input int tl, input int nidle);
    logic [31:0] d;
    logic [3:0] c;
    gap_q.push_back(prev_gap);
    put(4'b0001, {nb(), nb(), nb(), 8'hFB});
    for (int i = 0; i < ncol - 2; i++) put(4'b0000, {nb(), nb(), nb(), nb()});
    for (int l = 0; l < 4; l++) begin
      if (l < tl) begin d[8*l +: 8] = nb(); c[l] = 1'b0; end
      else if (l == tl) begin d[8*l +: 8] = 8'hFD; c[l] = 1'b1; end
      else begin d[8*l +: 8] = 8'h07; c[l] = 1'b1; end
    end
    put(c, d);
    idles(nidle);
    prev_gap = (4 - tl) + 4 * nidle;
  endtask

  task automatic do_reset();
    chk_en = 0;
    wr_rst_n = 0; rd_rst_n = 0;
    wr_ctrl = 4'hF; wr_data = IDLE4;
    repeat (6) @(posedge wclk);
    exp_q.delete(); gap_q.delete();
    prev_gap = 1000; o_gap = 1000; o_pkt = 0;
    #1 wr_rst_n = 1; rd_rst_n = 1;
    @(negedge rclk);
    chk({rd_ctrl, rd_data} == IDLECOL && !wr_ovf && !rd_unf, "R10",
        $sformatf("%h ovf=%b unf=%b", {rd_ctrl, rd_data}, wr_ovf, rd_unf),
        $sformatf("%h ovf=0 unf=0", IDLECOL));
  endtask

  always @(negedge rclk) if (chk_en) begin
    automatic logic [35:0] col = {rd_ctrl, rd_data};
    if (col == IDLECOL) begin
      if (o_pkt && !rd_unf) chk(0, "R8", "idle column inside packet", "packet data");
      o_gap += 4;
    end else begin
      if (exp_q.size() == 0) chk(0, "R1", $sformatf("%h", col), "no column");
      else begin
        chk(col == exp_q[0], "R1/R2", $sformatf("%h", col), $sformatf("%h", exp_q[0]));
        void'(exp_q.pop_front());
      end
      if (col[32] && col[7:0] == 8'hFB) begin
        if (gap_q.size() == 0) chk(0, "R9", "unexpected start", "none");
        else begin
          automatic int g = gap_q.pop_front();
          automatic int need = (g < 8) ? g : 8;
          chk(o_gap >= need, (g < 8) ? "R7" : "R6",
              $sformatf("gap %0d", o_gap), $sformatf(">= %0d", need));
        end
        o_pkt = 1;
      end
      for (int l = 0; l < 4; l++)
        if (col[32+l] && col[8*l +: 8] == 8'hFD) begin
          o_pkt = 0; o_gap = 4 - l;
        end
    end
  end

  task automatic stream_test(input string req);
    idles(20);
    chk_en = 1;
    for (int p = 0; p < 60; p++)
      if (p % 2 == 0) send_pkt(8, 3, 1);
      else send_pkt(8, p % 4, 5);
    idles(100);
    repeat (60) @(posedge rclk);
    chk(exp_q.size() == 0 && gap_q.size() == 0, "R1",
        $sformatf("%0d columns left", exp_q.size()), "0 columns left");
    chk(!wr_ovf && !rd_unf, req, $sformatf("ovf=%b unf=%b", wr_ovf, rd_unf), "ovf=0 unf=0");
    chk_en = 0;
  endtask

  initial begin
    repeat (150000) @(posedge wclk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // write faster: deletions needed, minimum gaps kept
    wh = 4.0; rh = 4.2;
    do_reset();
    stream_test("R5");
    // read faster: insertions needed
    wh = 4.2; rh = 4.0;
    do_reset();
    stream_test("R8");
    // overflow inside one long packet
    wh = 4.0; rh = 4.2;
    do_reset();
    idles(20);
    send_pkt(400, 0, 2);
    repeat (20) @(posedge rclk);
    chk(wr_ovf === 1'b1, "R3", $sformatf("ovf=%b", wr_ovf), "ovf=1");
    idles(50);
    chk(wr_ovf === 1'b1, "R3", $sformatf("ovf=%b", wr_ovf), "ovf sticky 1");
    // underflow inside one long packet
    wh = 4.2; rh = 4.0;
    do_reset();
    idles(20);
    send_pkt(400, 0, 2);
    repeat (20) @(posedge rclk);
    chk(rd_unf === 1'b1, "R4", $sformatf("unf=%b", rd_unf), "unf=1");
    idles(50);
    chk(rd_unf === 1'b1 && wr_ovf === 1'b0, "R4",
        $sformatf("unf=%b ovf=%b", rd_unf, wr_ovf), "unf=1 ovf=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule